// File: doc/BRIEF.md
# Dual-Phase Serial Frame Receiver

This block turns a serial data stream into parallel words. A bit clock, a frame sync and a data line come in as level signals. The block samples them inside the system clock domain and acts on each falling edge of the bit clock. A frame begins on a falling edge where frame sync is high. Data starts on the next falling edge, which gives a one-bit data delay, and bits arrive most significant first.

A frame takes one of two shapes. In single-phase mode it holds a configurable number of words, all of the same length. In dual-phase mode it holds exactly two words, and each of the two phases has its own word length. This shape suits left/right audio sample pairs. Each finished word is placed right-justified on a 32-bit bus with a one-cycle valid strobe and a phase flag. The word stays on the bus until the next one replaces it. A consumer acknowledges each word with a read strobe. A word that completes while its predecessor is still unread raises a sticky overrun flag.

Top module: `serial_frame_rx`

## Requirements
- R1: While rst_ni is low, valid_o, overrun_o and phase_o are 0 and word_o is all zeros.
- R2: A falling bit-clock edge that sees fsync_i high starts a frame and carries no data. The first data bit is taken on the next falling edge.
- R3: Bits are taken most significant first. Each word appears right-justified on word_o, and every bit above the word length is zero.
- R4: The word-length code maps 0→8, 1→12, 2→16, 3→20, 4→24 and 5→32 bits. Codes 6 and 7 also give 32 bits.
- R5: With dual_phase_i = 0, a frame holds frame_len_i + 1 words (frame_len_i is 7 bits, so up to 128 words). Every word uses wlen1_i and reports phase_o = 0.
- R6: With dual_phase_i = 1, a frame holds exactly two words whatever frame_len_i holds. The first word uses wlen1_i and reports phase_o = 0. The second uses wlen2_i and reports phase_o = 1.
- R7: valid_o is high for exactly one clock. That clock follows the clock edge where the falling bit-clock edge carrying the word's last bit is seen. word_o changes only together with valid_o.
- R8: A word that completes while the previous word is unread still replaces it, and overrun_o is set. overrun_o stays set until rd_i, which clears the pending word and overrun_o on the next clock.
- R9: After the last word of a frame, data bits produce no output until the next frame sync.
- R10: Frame sync seen in the middle of a frame drops the partial word and starts a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bclk_i | input | 1 | Bit clock, sampled in clk_i domain |
| fsync_i | input | 1 | Frame sync, active high |
| sdata_i | input | 1 | Serial data in |
| dual_phase_i | input | 1 | 0: single-phase frame, 1: dual-phase frame |
| frame_len_i | input | 7 | Words per frame minus one (single-phase only) |
| wlen1_i | input | 3 | Word-length code, phase 1 |
| wlen2_i | input | 3 | Word-length code, phase 2 |
| rd_i | input | 1 | Read acknowledge for the current word |
| word_o | output | 32 | Last completed word, right-justified |
| valid_o | output | 1 | One-cycle strobe for a new word |
| phase_o | output | 1 | Phase of word_o (0 first, 1 second) |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
A falling bit-clock edge is seen at one system clock edge. A word is due on the outputs right after the edge that samples its last bit, and overrun_o moves at that same edge. A read clears the pending word and overrun_o one clock after rd_i is sampled. The bench numbers every falling edge it produces, and a monitor captures each valid word with the edge number current at that time. Each captured word must therefore carry exactly the number of the edge that delivered its last bit. Level checks on overrun_o and the held word are sampled on falling system-clock edges at least one clock after the edge that updates them.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int WLEN_W = 3;
  localparam int CNT_W  = 6;

  typedef enum logic {
    ST_IDLE,
    ST_DATA
  } rx_state_e;

  // word-length code to bit count; reserved codes fall back to 32
  function automatic logic [CNT_W-1:0] wlen_bits(input logic [WLEN_W-1:0] code);
    logic [CNT_W-1:0] n;
    case (code)
      3'd0:    n = 6'd8;
      3'd1:    n = 6'd12;
      3'd2:    n = 6'd16;
      3'd3:    n = 6'd20;
      3'd4:    n = 6'd24;
      default: n = 6'd32;
    endcase
    return n;
  endfunction
endpackage

// File: rtl/srx_edge.sv
module srx_edge (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bclk_i,
  output logic fall_o
);
  logic bclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) bclk_q <= 1'b0;
    else         bclk_q <= bclk_i;
  end

  assign fall_o = bclk_q & ~bclk_i;
endmodule

// File: rtl/srx_seq.sv
module srx_seq
  import srx_pkg::*;
#(
  parameter int FLEN_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fall_i,
  input  logic              fsync_i,
  input  logic              dual_i,
  input  logic [FLEN_W-1:0] frame_len_i,
  input  logic [WLEN_W-1:0] wlen1_i,
  input  logic [WLEN_W-1:0] wlen2_i,
  output logic              shift_o,
  output logic              clr_o,
  output logic              done_o,
  output logic              phase_o
);
  localparam logic [FLEN_W-1:0] WORD_ONE = FLEN_W'(1);
  localparam logic [CNT_W-1:0]  BIT_ONE  = CNT_W'(1);

  rx_state_e         state_q;
  logic [CNT_W-1:0]  bit_cnt_q;
  logic [FLEN_W-1:0] word_cnt_q;
  logic              phase_q;

  logic [CNT_W-1:0]  cur_len;
  logic              word_end;
  logic              last_word;

  always_comb begin
    cur_len   = wlen_bits(phase_q ? wlen2_i : wlen1_i);
    word_end  = (bit_cnt_q == cur_len - BIT_ONE);
    last_word = dual_i ? phase_q : (word_cnt_q == frame_len_i);
    clr_o     = fall_i & fsync_i;
    shift_o   = fall_i & ~fsync_i & (state_q == ST_DATA);
    done_o    = shift_o & word_end;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      bit_cnt_q  <= '0;
      word_cnt_q <= '0;
      phase_q    <= 1'b0;
    end else if (clr_o) begin
      state_q    <= ST_DATA;
      bit_cnt_q  <= '0;
      word_cnt_q <= '0;
      phase_q    <= 1'b0;
    end else if (shift_o) begin
      if (word_end) begin
        bit_cnt_q <= '0;
        if (last_word)   state_q    <= ST_IDLE;
        else if (dual_i) phase_q    <= 1'b1;
        else             word_cnt_q <= word_cnt_q + WORD_ONE;
      end else begin
        bit_cnt_q <= bit_cnt_q + BIT_ONE;
      end
    end
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/srx_shift.sv
module srx_shift #(
  parameter int DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              clr_i,
  input  logic              done_i,
  input  logic              phase_i,
  input  logic              sdata_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] word_o,
  output logic              valid_o,
  output logic              phase_o,
  output logic              overrun_o
);
  logic [DATA_W-1:0] acc_q;
  logic [DATA_W-1:0] next_word;
  logic              pending_q;

  assign next_word = {acc_q[DATA_W-2:0], sdata_i};

  // accumulator restarts empty per word, so results come out zero-extended
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                acc_q <= '0;
    else if (clr_i || done_i)   acc_q <= '0;
    else if (shift_i)           acc_q <= next_word;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_o  <= '0;
      phase_o <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= done_i;
      if (done_i) begin
        word_o  <= next_word;
        phase_o <= phase_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pending_q <= 1'b0;
      overrun_o <= 1'b0;
    end else begin
      if (done_i)    pending_q <= 1'b1;
      else if (rd_i) pending_q <= 1'b0;
      if (rd_i)                      overrun_o <= 1'b0;
      else if (done_i && pending_q)  overrun_o <= 1'b1;
    end
  end
endmodule

// File: rtl/serial_frame_rx.sv
module serial_frame_rx
  import srx_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int FLEN_W = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bclk_i,
  input  logic              fsync_i,
  input  logic              sdata_i,
  input  logic              dual_phase_i,
  input  logic [FLEN_W-1:0] frame_len_i,
  input  logic [WLEN_W-1:0] wlen1_i,
  input  logic [WLEN_W-1:0] wlen2_i,
  input  logic              rd_i,
  output logic [DATA_W-1:0] word_o,
  output logic              valid_o,
  output logic              phase_o,
  output logic              overrun_o
);
  logic fall;
  logic shift;
  logic clr;
  logic done;
  logic seq_phase;

  srx_edge i_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bclk_i (bclk_i),
    .fall_o (fall)
  );

  srx_seq #(.FLEN_W(FLEN_W)) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fall_i      (fall),
    .fsync_i     (fsync_i),
    .dual_i      (dual_phase_i),
    .frame_len_i (frame_len_i),
    .wlen1_i     (wlen1_i),
    .wlen2_i     (wlen2_i),
    .shift_o     (shift),
    .clr_o       (clr),
    .done_o      (done),
    .phase_o     (seq_phase)
  );

  srx_shift #(.DATA_W(DATA_W)) i_shift (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .shift_i   (shift),
    .clr_i     (clr),
    .done_i    (done),
    .phase_i   (seq_phase),
    .sdata_i   (sdata_i),
    .rd_i      (rd_i),
    .word_o    (word_o),
    .valid_o   (valid_o),
    .phase_o   (phase_o),
    .overrun_o (overrun_o)
  );
endmodule

// File: rtl/srx_chk.sv
module srx_chk
  import srx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              dual_phase_i,
  input logic [WLEN_W-1:0] wlen1_i,
  input logic [WLEN_W-1:0] wlen2_i,
  input logic              rd_i,
  input logic [DATA_W-1:0] word_o,
  input logic              valid_o,
  input logic              phase_o,
  input logic              overrun_o
);
  logic [2*DATA_W-1:0] wide_word;
  logic [CNT_W-1:0]    out_len;

  assign wide_word = {{DATA_W{1'b0}}, word_o};
  assign out_len   = wlen_bits(phase_o ? wlen2_i : wlen1_i);

  // R7
  valid_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |=> !valid_o);

  // R7
  word_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> $stable(word_o));

  // R3
  upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> ((wide_word >> out_len) == '0));

  // R5
  single_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !dual_phase_i) |-> !phase_o);

  // R8
  overrun_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> valid_o);

  // R8
  read_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> !overrun_o);
endmodule

bind serial_frame_rx srx_chk #(.DATA_W(DATA_W)) i_srx_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .dual_phase_i (dual_phase_i),
  .wlen1_i      (wlen1_i),
  .wlen2_i      (wlen2_i),
  .rd_i         (rd_i),
  .word_o       (word_o),
  .valid_o      (valid_o),
  .phase_o      (phase_o),
  .overrun_o    (overrun_o)
);

// File: tb/test_serial_frame_rx.sv
`timescale 1ns/1ps
module test_serial_frame_rx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bclk = 1'b0;
  logic        fs = 1'b0;
  logic        sd = 1'b0;
  logic        dual = 1'b0;
  logic        rd = 1'b0;
  logic [6:0]  flen = '0;
  logic [2:0]  wl1 = '0;
  logic [2:0]  wl2 = '0;
  logic [31:0] word;
  logic        valid;
  logic        ph;
  logic        ovr;

  always #4 clk = ~clk;

  serial_frame_rx i_serial_frame_rx (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .bclk_i       (bclk),
    .fsync_i      (fs),
    .sdata_i      (sd),
    .dual_phase_i (dual),
    .frame_len_i  (flen),
    .wlen1_i      (wl1),
    .wlen2_i      (wl2),
    .rd_i         (rd),
    .word_o       (word),
    .valid_o      (valid),
    .phase_o      (ph),
    .overrun_o    (ovr)
  );

  int n_chk = 0;
  int n_fail = 0;
  int bit_no = 0;
  bit auto_rd = 1'b1;
  bit man_rd = 1'b0;
  bit finished = 1'b0;
  bit prev_valid = 1'b0;

  logic [31:0] exp_w [0:255];
  logic        exp_p [0:255];
  int          exp_b [0:255];
  int          exp_n = 0;
  logic [31:0] cap_w [0:255];
  logic        cap_p [0:255];
  int          cap_b [0:255];
  int          cap_n = 0;

  always @(negedge clk) begin
    if (rst_n && valid) begin
      if (cap_n < 256) begin
        cap_w[cap_n] = word;
        cap_p[cap_n] = ph;
        cap_b[cap_n] = bit_no;
      end
      cap_n++;
    end
    if (valid && prev_valid) begin
      n_chk++;
      n_fail++;
      $display("FAIL R7 valid wider than one cycle: actual 2 expected 1");
    end
    prev_valid = valid;
    rd = (auto_rd && valid) || man_rd;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  function automatic int len_of(input int code);
    case (code)
      0: return 8;
      1: return 12;
      2: return 16;
      3: return 20;
      4: return 24;
      default: return 32;
    endcase
  endfunction

  function automatic logic [31:0] pat(input int seed, input int w, input int len);
    logic [31:0] x;
    logic [63:0] m;
    x = 32'(seed) * 32'h9E3779B1 ^ 32'(w + 1) * 32'h85EBCA6B;
    x = x ^ (x >> 13) ^ 32'h8000_0001;
    m = (64'd1 << len) - 64'd1;
    return x & m[31:0];
  endfunction

  task automatic tick_bit(input logic f, input logic d);
    @(negedge clk);
    bclk = 1'b1;
    fs = f;
    sd = d;
    @(negedge clk);
    @(negedge clk);
    bclk = 1'b0;
    @(posedge clk);
    bit_no++;
  endtask

  task automatic send_frame(input bit dm, input int fl, input int c1, input int c2,
                            input int seed, input int tail);
    int nw;
    @(negedge clk);
    dual = dm;
    flen = 7'(fl);
    wl1 = 3'(c1);
    wl2 = 3'(c2);
    nw = dm ? 2 : fl + 1;
    tick_bit(1'b1, 1'b1);
    for (int w = 0; w < nw; w++) begin
      int len;
      logic [31:0] v;
      len = len_of((dm && w == 1) ? c2 : c1);
      v = pat(seed, w, len);
      for (int j = 0; j < len; j++) tick_bit(1'b0, v[len-1-j]);
      exp_w[exp_n] = v;
      exp_p[exp_n] = dm ? w[0] : 1'b0;
      exp_b[exp_n] = bit_no;
      exp_n++;
    end
    for (int j = 0; j < tail; j++) tick_bit(1'b0, j[0]);
  endtask

  task automatic check_case(input string req, input string preq);
    int n;
    repeat (3) @(negedge clk);
    chk(cap_n == exp_n, req, "word count", 32'(cap_n), 32'(exp_n));
    n = (cap_n < exp_n) ? cap_n : exp_n;
    for (int i = 0; i < n; i++) begin
      chk(cap_w[i] === exp_w[i], req, "word value", cap_w[i], exp_w[i]);
      chk(cap_p[i] === exp_p[i], preq, "phase flag", 32'(cap_p[i]), 32'(exp_p[i]));
      chk(cap_b[i] == exp_b[i], "R7", "valid timing (edge number)", 32'(cap_b[i]), 32'(exp_b[i]));
    end
    cap_n = 0;
    exp_n = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL R7 watchdog expired: actual 1 expected 0");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(valid == 1'b0, "R1", "valid in reset", 32'(valid), 32'd0);
    chk(ovr == 1'b0, "R1", "overrun in reset", 32'(ovr), 32'd0);
    chk(ph == 1'b0, "R1", "phase in reset", 32'(ph), 32'd0);
    chk(word == 32'd0, "R1", "word in reset", word, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R4 R5 R9: every word-length code, three words per frame, junk after
    for (int c = 0; c < 8; c++) begin
      send_frame(1'b0, 2, c, 7 - c, c + 1, 12);
      check_case("R2 R3 R4 R9", "R5");
    end

    // R6: all legal code pairs, frame_len_i nonzero and ignored
    for (int a = 0; a < 6; a++) begin
      for (int b = 0; b < 6; b++) begin
        send_frame(1'b1, a * 6 + b + 1, a, b, 100 + a * 6 + b, 8);
        check_case("R3 R4 R6 R9", "R6");
      end
    end

    // R5 boundaries: 128-word frame, then single-word frame
    send_frame(1'b0, 127, 0, 0, 55, 20);
    check_case("R5 R9", "R5");
    send_frame(1'b0, 0, 5, 0, 56, 40);
    check_case("R5 R9", "R5");

    // R10: partial frame cut by a new frame sync
    tick_bit(1'b1, 1'b0);
    for (int j = 0; j < 7; j++) tick_bit(1'b0, 1'b1);
    send_frame(1'b0, 1, 2, 0, 77, 4);
    check_case("R10", "R5");
    tick_bit(1'b1, 1'b0);
    send_frame(1'b1, 0, 5, 3, 78, 4);
    check_case("R10", "R6");

    // R8 overrun: no reads during a dual frame
    auto_rd = 1'b0;
    send_frame(1'b1, 0, 1, 4, 90, 2);
    repeat (2) @(negedge clk);
    chk(ovr == 1'b1, "R8", "overrun set", 32'(ovr), 32'd1);
    chk(word == exp_w[1], "R8", "newer word kept", word, exp_w[1]);
    chk(ph == 1'b1, "R8", "newer word phase", 32'(ph), 32'd1);
    check_case("R8", "R6");
    @(posedge clk);
    #1 man_rd = 1'b1;
    @(posedge clk);
    @(posedge clk);
    #1 man_rd = 1'b0;
    repeat (2) @(negedge clk);
    chk(ovr == 1'b0, "R8", "overrun cleared by read", 32'(ovr), 32'd0);
    // one unread word after a read: no overrun
    send_frame(1'b0, 0, 0, 0, 91, 2);
    repeat (2) @(negedge clk);
    chk(ovr == 1'b0, "R8", "single unread word", 32'(ovr), 32'd0);
    check_case("R8", "R5");

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule